// File: doc/BRIEF.md
# Column Hit Sparsifier Encoder

This block turns one scanned pixel column into address-tagged hit words. Each cycle it can accept an 8-bit vector with one bit per pixel row, the address of the column and the time-stamp of the current time window. In a single clock it encodes every set bit into a fixed-format 17-bit word. It packs those words into the lowest lanes of an eight-lane output bus and reports how many lanes are in use.

A matrix scanner drives the block one column per cycle. A downstream queue writes the first `hit_cnt_o` lanes of the bus. The column address splits into a macro-column part in the upper three bits and a column-within-macro-pixel part in the lower two bits. The outputs are registered, so one input column produces one result a single cycle later, and back-to-back columns stream with no gaps.

Top module: `cs_col_sparsifier`

## Requirements
- R1: While `rst_n` is low, and on the first edges after it rises with no strobe, every lane word reads all zero and `hit_cnt_o` reads 0, whatever the inputs are.
- R2: The result for a column sampled at a rising edge with `col_vld_i` high appears on the outputs just after that edge. Until then, the outputs keep the previous result.
- R3: With `col_vld_i` high, `hit_cnt_o` equals the number of set bits in `col_hits_i`, from 0 to 8.
- R4: With `col_vld_i` low, the next result has `hit_cnt_o` = 0 and every lane all zero, whatever `col_hits_i` holds.
- R5: Lanes 0 to `hit_cnt_o`-1 carry a valid flag of 1, and all higher lanes carry a valid flag of 0.
- R6: Lane k holds the hit of the k-th lowest set row, so row fields rise strictly from lane 0 upward.
- R7: Lane k occupies bits [17k+16:17k] of `lanes_o`. Within a word, bit 16 is the valid flag, bits 15:13 are the row index, bits 12:11 are `col_addr_i[1:0]`, bits 10:8 are `col_addr_i[4:2]`, and bits 7:0 are `tstamp_i`.
- R8: A lane whose valid flag is 0 is all zero.
- R9: A column with all eight rows hit fills every lane, with rows 0 through 7 in lanes 0 through 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| col_vld_i | input | 1 | Qualifies the column on this cycle |
| col_hits_i | input | 8 | One hit bit per pixel row, bit 0 = row 0 |
| col_addr_i | input | 5 | Column address: macro-column in [4:2], column within macro-pixel in [1:0] |
| tstamp_i | input | 8 | Time-stamp attached to every hit |
| lanes_o | output | 136 | Eight packed 17-bit hit words, lane 0 in the low bits |
| hit_cnt_o | output | 4 | Number of valid lanes, 0 to 8 |

## Verification
The bench drives all 256 hit patterns with the strobe high, changing the address and time-stamp for each one, and predicts each lane by walking the rows in ascending order. This catches a packer that leaves gaps, reverses the order, or drops a row at either end of the column. It also catches a formatter that swaps the two address fields. The bench replays patterns with the strobe low, so a design that encodes unqualified columns shows a nonzero count. Probes just after the input changes catch a combinational path that skips the register. The full column and the empty column cover the two ends of the count range, and a reset asserted mid-stream must clear a pending full result.

// File: rtl/cs_pkg.sv
package cs_pkg;
    // Default geometry of one scanned column
    localparam int CS_ROWS   = 8;
    localparam int CS_PCOL_W = 2;
    localparam int CS_MCOL_W = 3;
    localparam int CS_TS_W   = 8;
endpackage

// File: rtl/cs_hit_rank.sv
// Prefix count over the hit vector: rank of each row among set rows below it,
// plus the total number of hits.
module cs_hit_rank #(
    parameter int ROWS  = 8,
    parameter int CNT_W = 4
) (
    input  logic [ROWS-1:0]       hits_i,
    output logic [ROWS*CNT_W-1:0] rank_o,
    output logic [CNT_W-1:0]      total_o
);
    logic [CNT_W-1:0] acc;

    always_comb begin
        acc    = '0;
        rank_o = '0;
        for (int r = 0; r < ROWS; r++) begin
            rank_o[r*CNT_W +: CNT_W] = acc;
            acc = acc + CNT_W'(hits_i[r]);
        end
        total_o = acc;
    end
endmodule

// File: rtl/cs_word_fmt.sv
// Builds one candidate hit word per row: {valid, row, pcol, mcol, ts}.
module cs_word_fmt #(
    parameter int ROWS   = 8,
    parameter int ROW_W  = 3,
    parameter int PCOL_W = 2,
    parameter int MCOL_W = 3,
    parameter int TS_W   = 8,
    localparam int WORD_W = 1 + ROW_W + PCOL_W + MCOL_W + TS_W
) (
    input  logic [PCOL_W+MCOL_W-1:0] addr_i,
    input  logic [TS_W-1:0]          ts_i,
    output logic [ROWS*WORD_W-1:0]   words_o
);
    logic [PCOL_W-1:0] pcol;
    logic [MCOL_W-1:0] mcol;

    assign pcol = addr_i[PCOL_W-1:0];
    assign mcol = addr_i[PCOL_W+MCOL_W-1:PCOL_W];

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign words_o[r*WORD_W +: WORD_W] = {1'b1, ROW_W'(r), pcol, mcol, ts_i};
    end
endmodule

// File: rtl/cs_lane_pack.sv
// Routes the word of each hit row to the lane given by its rank.
module cs_lane_pack #(
    parameter int ROWS   = 8,
    parameter int CNT_W  = 4,
    parameter int WORD_W = 17
) (
    input  logic [ROWS-1:0]        hits_i,
    input  logic [ROWS*CNT_W-1:0]  rank_i,
    input  logic [ROWS*WORD_W-1:0] words_i,
    output logic [ROWS*WORD_W-1:0] lanes_o
);
    for (genvar k = 0; k < ROWS; k++) begin : g_lane
        logic [WORD_W-1:0] sel;
        always_comb begin
            sel = '0;
            for (int r = 0; r < ROWS; r++) begin
                if (hits_i[r] && (rank_i[r*CNT_W +: CNT_W] == CNT_W'(k))) begin
                    sel = sel | words_i[r*WORD_W +: WORD_W];
                end
            end
        end
        assign lanes_o[k*WORD_W +: WORD_W] = sel;
    end
endmodule

// File: rtl/cs_col_sparsifier.sv
module cs_col_sparsifier
    import cs_pkg::*;
#(
    parameter int ROWS   = CS_ROWS,
    parameter int PCOL_W = CS_PCOL_W,
    parameter int MCOL_W = CS_MCOL_W,
    parameter int TS_W   = CS_TS_W,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int CNT_W  = $clog2(ROWS + 1),
    localparam int ADDR_W = PCOL_W + MCOL_W,
    localparam int WORD_W = 1 + ROW_W + PCOL_W + MCOL_W + TS_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     col_vld_i,
    input  logic [ROWS-1:0]          col_hits_i,
    input  logic [ADDR_W-1:0]        col_addr_i,
    input  logic [TS_W-1:0]          tstamp_i,
    output logic [ROWS*WORD_W-1:0]   lanes_o,
    output logic [CNT_W-1:0]         hit_cnt_o
);
    localparam int VLD_BIT = WORD_W - 1;
    localparam int ROW_LO  = WORD_W - 1 - ROW_W;

    typedef struct packed {
        logic [ROWS*WORD_W-1:0] lanes;
        logic [CNT_W-1:0]       cnt;
    } state_t;

    state_t st_d, st_q;

    logic [ROWS*CNT_W-1:0]  rank;
    logic [CNT_W-1:0]       total;
    logic [ROWS*WORD_W-1:0] row_words;
    logic [ROWS*WORD_W-1:0] packed_lanes;

    cs_hit_rank #(.ROWS(ROWS), .CNT_W(CNT_W)) u_rank (
        .hits_i  (col_hits_i),
        .rank_o  (rank),
        .total_o (total)
    );

    cs_word_fmt #(
        .ROWS(ROWS), .ROW_W(ROW_W), .PCOL_W(PCOL_W), .MCOL_W(MCOL_W), .TS_W(TS_W)
    ) u_fmt (
        .addr_i  (col_addr_i),
        .ts_i    (tstamp_i),
        .words_o (row_words)
    );

    cs_lane_pack #(.ROWS(ROWS), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_pack (
        .hits_i  (col_hits_i),
        .rank_i  (rank),
        .words_i (row_words),
        .lanes_o (packed_lanes)
    );

    always_comb begin
        st_d = '0;
        if (col_vld_i) begin
            st_d.lanes = packed_lanes;
            st_d.cnt   = total;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lanes_o   = st_q.lanes;
    assign hit_cnt_o = st_q.cnt;

    // Checks on the registered result
    logic [ROWS-1:0] vld_bits;
    for (genvar k = 0; k < ROWS; k++) begin : g_vld
        assign vld_bits[k] = lanes_o[k*WORD_W + VLD_BIT];
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt_o <= CNT_W'(ROWS)); // R3

    AST_CNT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        col_vld_i |=> hit_cnt_o == CNT_W'($countones($past(col_hits_i)))); // R3

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !col_vld_i |=> (hit_cnt_o == '0 && lanes_o == '0)); // R4

    AST_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cnt_o == CNT_W'($countones(vld_bits))); // R5

    AST_THERMO: assert property (@(posedge clk) disable iff (!rst_n)
        ((vld_bits + ROWS'(1)) & vld_bits) == '0); // R5

    AST_TS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (col_vld_i && |col_hits_i) |=> lanes_o[TS_W-1:0] == $past(tstamp_i)); // R7

    for (genvar k = 1; k < ROWS; k++) begin : g_chk_order
        AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
            vld_bits[k] |-> lanes_o[k*WORD_W + ROW_LO +: ROW_W]
                          > lanes_o[(k-1)*WORD_W + ROW_LO +: ROW_W]); // R6
    end

    for (genvar k = 0; k < ROWS; k++) begin : g_chk_zero
        AST_EMPTY_LANE: assert property (@(posedge clk) disable iff (!rst_n)
            !vld_bits[k] |-> lanes_o[k*WORD_W +: WORD_W] == '0); // R8
    end
endmodule

// File: tb/sim_cs_col_sparsifier.sv
`timescale 1ns/1ps
module sim_cs_col_sparsifier;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         col_vld_i = 1'b0;
    logic [7:0]   col_hits_i = '0;
    logic [4:0]   col_addr_i = '0;
    logic [7:0]   tstamp_i = '0;
    logic [135:0] lanes_o;
    logic [3:0]   hit_cnt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    cs_col_sparsifier u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .col_vld_i  (col_vld_i),
        .col_hits_i (col_hits_i),
        .col_addr_i (col_addr_i),
        .tstamp_i   (tstamp_i),
        .lanes_o    (lanes_o),
        .hit_cnt_o  (hit_cnt_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected result computed from the requirements
    task automatic check_result(input bit vld, input logic [7:0] hits,
                                input logic [4:0] addr, input logic [7:0] ts);
        logic [16:0] exp [8];
        int n = 0;
        for (int k = 0; k < 8; k++) exp[k] = '0;
        if (vld) begin
            for (int r = 0; r < 8; r++) begin
                if (hits[r]) begin
                    exp[n] = {1'b1, 3'(r), addr[1:0], addr[4:2], ts};
                    n++;
                end
            end
        end
        chk(vld ? "R3" : "R4", "count", 32'(hit_cnt_o), 32'(n));
        for (int k = 0; k < 8; k++) begin
            chk(k < n ? "R6/R7" : "R5/R8", $sformatf("lane%0d", k),
                32'(lanes_o[k*17 +: 17]), 32'(exp[k]));
        end
    endtask

    task automatic drive(input bit vld, input logic [7:0] hits,
                         input logic [4:0] addr, input logic [7:0] ts);
        @(negedge clk);
        col_vld_i  = vld;
        col_hits_i = hits;
        col_addr_i = addr;
        tstamp_i   = ts;
    endtask

    initial begin : main
        // R1: reset holds outputs at zero even with a busy column applied
        drive(1'b1, 8'hFF, 5'h1F, 8'hAA);
        repeat (2) @(negedge clk);
        chk("R1", "reset count", 32'(hit_cnt_o), 32'd0);
        chk("R1", "reset lanes", 32'(|lanes_o), 32'd0);
        drive(1'b0, 8'h00, 5'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset count", 32'(hit_cnt_o), 32'd0);

        // Exhaustive sweep of the hit vector with the strobe high
        for (int hv = 0; hv < 256; hv++) begin
            logic [7:0] prev_cnt;
            logic [4:0] a;
            logic [7:0] t;
            prev_cnt = 8'(hit_cnt_o);
            a = 5'((hv * 7 + 3) % 32);
            t = 8'(hv * 13 + 5);
            drive(1'b1, 8'(hv), a, t);
            if (hv % 16 == 1) begin
                #0.5;
                chk("R2", "before edge", 32'(hit_cnt_o), 32'(prev_cnt));
            end
            @(negedge clk);
            check_result(1'b1, 8'(hv), a, t);
            if (hv == 255) chk("R9", "full column count", 32'(hit_cnt_o), 32'd8);
        end

        // R4: strobe low hides any hits
        for (int hv = 1; hv < 256; hv += 17) begin
            drive(1'b0, 8'(hv), 5'(hv), 8'(~hv));
            @(negedge clk);
            check_result(1'b0, 8'(hv), 5'(hv), 8'(~hv));
        end

        // Back-to-back columns: each result follows its own column (R2)
        drive(1'b1, 8'h81, 5'h05, 8'h11);
        drive(1'b1, 8'h18, 5'h1A, 8'h22);
        check_result(1'b1, 8'h81, 5'h05, 8'h11);
        @(negedge clk);
        check_result(1'b1, 8'h18, 5'h1A, 8'h22);

        // R1: reset mid-stream clears a pending full column
        drive(1'b1, 8'hFF, 5'h12, 8'h34);
        @(negedge clk);
        chk("R9", "full column before reset", 32'(hit_cnt_o), 32'd8);
        rst_n = 1'b0;
        #0.5;
        chk("R1", "async reset count", 32'(hit_cnt_o), 32'd0);
        chk("R1", "async reset lanes", 32'(|lanes_o), 32'd0);
        @(negedge clk);
        col_vld_i = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check_result(1'b0, 8'hFF, 5'h12, 8'h34);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule